// File: doc/BRIEF.md
# SD Host Event Status and Interrupt Unit

This unit holds the event flags of an SD/MMC host controller and turns them into one interrupt line. The command engine, the data engine and the card-detect logic each report events as single-cycle pulses. Each pulse sets a sticky bit in one of two byte-wide status registers. A bit stays set until software writes a one to its position. Writing zero to a position leaves that bit alone, so software can write back a value it has just read and clear exactly the events it has handled.

A second kind of status bit shows the present level of an input: write protect, the two card-detect sources and the two busy flags. These bits are never latched and cannot be written. Two mask registers choose which sticky events may interrupt. A global enable bit gates the result. The unit registers the interrupt line, so it follows the status by one clock.

Software reaches every register over a simple byte bus with an address, a write strobe, a read strobe and read and write data. Reads are combinational and return zero when the read strobe is low.

Top module: `sdh_evt_status`

## Requirements
- R1: After a synchronous reset, all sticky status bits, both masks, the global enable and the clock-freeze control read 0, and `irq` is 0.
- R2: A one on an event input in a cycle sets its status bit at that clock edge. The four `grp0_evt` inputs (bits 0..3) map to status 0 (address 0x28) bits 4..7: multi-block done, block done, card-detect change, device inserted. Input `grp1_evt[i]` maps to status 1 (address 0x29) bit i: 0 card interrupt, 1 command done, 2 response timeout, 3 auto-stop done, 4 data timeout, 5 response CRC error, 6 read CRC error, 7 write CRC error.
- R3: A write to 0x28 or 0x29 clears the sticky bits where the written data holds a one and leaves all other bits unchanged. Writing 0xFF clears every sticky bit of that register.
- R4: If an event pulse and a clearing write hit the same bit in the same cycle, the bit stays set.
- R5: Status 0 bit 1 shows `wp_lvl`, bit 2 shows `cd_dat3_lvl` and bit 3 shows `cd_gpi_lvl`. Status 2 (0x2A) bit 4 shows `cmd_busy_lvl` and bit 5 shows `dat_busy_lvl`. These bits follow their inputs and writes do not change them.
- R6: Status 2 bit 7 is a read/write control bit that drives `clk_freeze_en`. No other bit of status 2 can be written.
- R7: Mask 0 (0x24) has writable bits 4..7 and mask 1 (0x25) has writable bits 1..7. All other mask bits read 0.
- R8: The global interrupt enable is bit 7 of address 0x0D, the upper byte of the 16-bit block-length register. While it is 0, `irq` is 0.
- R9: `irq` is a register. It is 1 one clock after some sticky bit and its mask bit are both 1 with the global enable set, and it returns to 0 one clock after no such pair remains.
- R10: The card-interrupt event (status 1 bit 0) is sticky but has no mask bit, so it never raises `irq`.
- R11: Status 3 (0x2B) and unmapped addresses read 0 and ignore writes. `rdata` is 0 while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Register byte address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| grp0_evt | input | 4 | Event pulses for status 0 bits 4..7 |
| grp1_evt | input | 8 | Event pulses for status 1 bits 0..7 |
| wp_lvl | input | 1 | Write-protect level |
| cd_dat3_lvl | input | 1 | Card-detect level sensed on DAT3 |
| cd_gpi_lvl | input | 1 | Card-detect level from the detect pin |
| cmd_busy_lvl | input | 1 | Command-response busy level |
| dat_busy_lvl | input | 1 | Data-response busy level |
| clk_freeze_en | output | 1 | Automatic clock-freeze enable |
| irq | output | 1 | Registered level interrupt |

## Verification
The hardest case to reach from the ports is an event pulse and a clearing write landing on the same bit at the same clock edge. The bench makes it happen by raising the event input and the write strobe on the same falling edge, so both are seen at the next rising edge. A second case needs exact timing: `irq` must still be low right after the edge that sets a status bit, and high one edge later. The bench samples just after each of those two edges, both when the interrupt rises and when it falls after a clear.

// File: rtl/sdh_evt_pkg.sv
package sdh_evt_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 8;
    localparam int N_GRP  = 2;

    localparam logic [ADDR_W-1:0] OFS_CTL_HI = 8'h0D;
    localparam logic [ADDR_W-1:0] OFS_MSK0   = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_MSK1   = 8'h25;
    localparam logic [ADDR_W-1:0] OFS_ST0    = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_ST1    = 8'h29;
    localparam logic [ADDR_W-1:0] OFS_ST2    = 8'h2A;

    // which positions latch events, which mask bits exist
    localparam logic [BYTE_W-1:0] STICKY0 = 8'hF0;
    localparam logic [BYTE_W-1:0] STICKY1 = 8'hFF;
    localparam logic [BYTE_W-1:0] MSKW0   = 8'hF0;
    localparam logic [BYTE_W-1:0] MSKW1   = 8'hFE;
    localparam logic [BYTE_W-1:0] CTLW    = 8'h80;
    localparam logic [BYTE_W-1:0] FRZW    = 8'h80;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTL,
        SEL_MSK0,
        SEL_MSK1,
        SEL_ST0,
        SEL_ST1,
        SEL_ST2
    } reg_sel_e;

    typedef struct packed {
        logic wp;
        logic cd_dat3;
        logic cd_gpi;
        logic cmd_busy;
        logic dat_busy;
    } live_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_CTL_HI: return SEL_CTL;
            OFS_MSK0:   return SEL_MSK0;
            OFS_MSK1:   return SEL_MSK1;
            OFS_ST0:    return SEL_ST0;
            OFS_ST1:    return SEL_ST1;
            OFS_ST2:    return SEL_ST2;
            default:    return SEL_NONE;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] pack_st0(input logic [BYTE_W-1:0] sticky,
                                                   input live_t lv);
        return {sticky[7:4], lv.cd_gpi, lv.cd_dat3, lv.wp, 1'b0};
    endfunction

    function automatic logic [BYTE_W-1:0] pack_st2(input logic frz, input live_t lv);
        return {frz, 1'b0, lv.dat_busy, lv.cmd_busy, 4'b0000};
    endfunction

endpackage

// File: rtl/sdh_w1c_byte.sv
module sdh_w1c_byte
    import sdh_evt_pkg::*;
#(
    parameter logic [BYTE_W-1:0] KEEP = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_en,
    input  logic [BYTE_W-1:0] clr_bits,
    input  logic [BYTE_W-1:0] set_bits,
    output logic [BYTE_W-1:0] q
);

    logic [BYTE_W-1:0] clr_eff;
    logic [BYTE_W-1:0] set_eff;

    always_comb begin
        clr_eff = clr_en ? clr_bits : '0;
        set_eff = set_bits & KEEP;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= ((q & ~clr_eff) | set_eff) & KEEP;
    end

    a_r2_event_sets: assert property (@(posedge clk) disable iff (rst)
        (|(set_bits & KEEP)) |=> ((q & $past(set_bits & KEEP)) == $past(set_bits & KEEP)));

    a_r3_clear_ones: assert property (@(posedge clk) disable iff (rst)
        (clr_en && ((set_bits & KEEP) == '0)) |=> ((q & $past(clr_bits)) == '0));

    a_r3_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!clr_en && ((set_bits & KEEP) == '0)) |=> $stable(q));

    a_r4_event_wins: assert property (@(posedge clk) disable iff (rst)
        (clr_en && (|(clr_bits & set_bits & KEEP)))
        |=> ((q & $past(clr_bits & set_bits & KEEP)) == $past(clr_bits & set_bits & KEEP)));

endmodule

// File: rtl/sdh_ctl_byte.sv
module sdh_ctl_byte
    import sdh_evt_pkg::*;
#(
    parameter logic [BYTE_W-1:0] WMASK = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (wr_en) q <= wdata & WMASK;
    end

    a_r7_hold_unwritten: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(q));

    a_r7_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (q == ($past(wdata) & WMASK)));

endmodule

// File: rtl/sdh_irq_merge.sv
module sdh_irq_merge
    import sdh_evt_pkg::*;
#(
    parameter int GRPS = N_GRP
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [GRPS-1:0][BYTE_W-1:0]  stat,
    input  logic [GRPS-1:0][BYTE_W-1:0]  mask,
    input  logic                         gen_en,
    output logic                         irq
);

    logic [GRPS-1:0] grp_hit;
    logic            any_hit;

    for (genvar g = 0; g < GRPS; g++) begin : g_grp
        assign grp_hit[g] = |(stat[g] & mask[g]);
    end

    assign any_hit = |grp_hit;

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= gen_en & any_hit;
    end

    a_r8_gate_off: assert property (@(posedge clk) disable iff (rst)
        !gen_en |=> !irq);

    a_r9_raise: assert property (@(posedge clk) disable iff (rst)
        (gen_en && any_hit) |=> irq);

    a_r9_drop: assert property (@(posedge clk) disable iff (rst)
        !any_hit |=> !irq);

endmodule

// File: rtl/sdh_evt_status.sv
module sdh_evt_status
    import sdh_evt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  addr,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    input  logic [3:0]  grp0_evt,
    input  logic [7:0]  grp1_evt,
    input  logic        wp_lvl,
    input  logic        cd_dat3_lvl,
    input  logic        cd_gpi_lvl,
    input  logic        cmd_busy_lvl,
    input  logic        dat_busy_lvl,
    output logic        clk_freeze_en,
    output logic        irq
);

    reg_sel_e          sel;
    live_t             lv;
    logic [BYTE_W-1:0] st0_q, st1_q, msk0_q, msk1_q, ctl_q, frz_q;
    logic [BYTE_W-1:0] rd_mux;
    logic [N_GRP-1:0][BYTE_W-1:0] st_vec, mk_vec;

    assign sel = decode_addr(addr);
    assign lv  = '{wp: wp_lvl, cd_dat3: cd_dat3_lvl, cd_gpi: cd_gpi_lvl,
                   cmd_busy: cmd_busy_lvl, dat_busy: dat_busy_lvl};

    sdh_w1c_byte #(.KEEP(STICKY0)) u_st0 (
        .clk(clk), .rst(rst),
        .clr_en(wr_en && sel == SEL_ST0), .clr_bits(wdata),
        .set_bits({grp0_evt, 4'b0000}), .q(st0_q)
    );

    sdh_w1c_byte #(.KEEP(STICKY1)) u_st1 (
        .clk(clk), .rst(rst),
        .clr_en(wr_en && sel == SEL_ST1), .clr_bits(wdata),
        .set_bits(grp1_evt), .q(st1_q)
    );

    sdh_ctl_byte #(.WMASK(MSKW0)) u_msk0 (
        .clk(clk), .rst(rst), .wr_en(wr_en && sel == SEL_MSK0),
        .wdata(wdata), .q(msk0_q)
    );

    sdh_ctl_byte #(.WMASK(MSKW1)) u_msk1 (
        .clk(clk), .rst(rst), .wr_en(wr_en && sel == SEL_MSK1),
        .wdata(wdata), .q(msk1_q)
    );

    sdh_ctl_byte #(.WMASK(CTLW)) u_ctl (
        .clk(clk), .rst(rst), .wr_en(wr_en && sel == SEL_CTL),
        .wdata(wdata), .q(ctl_q)
    );

    sdh_ctl_byte #(.WMASK(FRZW)) u_frz (
        .clk(clk), .rst(rst), .wr_en(wr_en && sel == SEL_ST2),
        .wdata(wdata), .q(frz_q)
    );

    assign st_vec = {st1_q, st0_q};
    assign mk_vec = {msk1_q, msk0_q};

    sdh_irq_merge #(.GRPS(N_GRP)) u_irq (
        .clk(clk), .rst(rst), .stat(st_vec), .mask(mk_vec),
        .gen_en(ctl_q[7]), .irq(irq)
    );

    assign clk_freeze_en = frz_q[7];

    always_comb begin
        unique case (sel)
            SEL_CTL:  rd_mux = ctl_q;
            SEL_MSK0: rd_mux = msk0_q;
            SEL_MSK1: rd_mux = msk1_q;
            SEL_ST0:  rd_mux = pack_st0(st0_q, lv);
            SEL_ST1:  rd_mux = st1_q;
            SEL_ST2:  rd_mux = pack_st2(frz_q[7], lv);
            default:  rd_mux = '0;
        endcase
        rdata = rd_en ? rd_mux : '0;
    end

    a_r11_quiet_bus: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rdata == '0));

    a_r5_live_st0: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == OFS_ST0) |-> (rdata[3:1] == {cd_gpi_lvl, cd_dat3_lvl, wp_lvl}));

    a_r1_reset_irq: assert property (@(posedge clk)
        $past(rst) |-> !irq);

endmodule

// File: tb/tb_sdh_evt_status.sv
`timescale 1ns/1ps
module tb_sdh_evt_status;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] addr;
    logic       wr_en, rd_en;
    logic [7:0] wdata, rdata;
    logic [3:0] grp0_evt;
    logic [7:0] grp1_evt;
    logic       wp_lvl, cd_dat3_lvl, cd_gpi_lvl, cmd_busy_lvl, dat_busy_lvl;
    logic       clk_freeze_en, irq;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    sdh_evt_status dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .grp0_evt(grp0_evt), .grp1_evt(grp1_evt),
        .wp_lvl(wp_lvl), .cd_dat3_lvl(cd_dat3_lvl), .cd_gpi_lvl(cd_gpi_lvl),
        .cmd_busy_lvl(cmd_busy_lvl), .dat_busy_lvl(dat_busy_lvl),
        .clk_freeze_en(clk_freeze_en), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [3:0] e0, input logic [7:0] e1);
        @(negedge clk);
        grp0_evt = e0; grp1_evt = e1;
        @(negedge clk);
        grp0_evt = '0; grp1_evt = '0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(8'h28, v); chk("R1 st0", v, 8'h00);
        rd(8'h29, v); chk("R1 st1", v, 8'h00);
        rd(8'h24, v); chk("R1 msk0", v, 8'h00);
        rd(8'h25, v); chk("R1 msk1", v, 8'h00);
        rd(8'h0D, v); chk("R1 ctl", v, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);
        chk("R1 freeze", {7'b0, clk_freeze_en}, 8'h00);
    endtask

    task automatic t_set_clear;
        logic [7:0] v;
        pulse(4'b1010, 8'h00);
        rd(8'h28, v); chk("R2 st0 map", v, 8'hA0);
        pulse(4'b0101, 8'h00);
        rd(8'h28, v); chk("R2 st0 accumulate", v, 8'hF0);
        pulse(4'b0000, 8'h5A);
        rd(8'h29, v); chk("R2 st1 map", v, 8'h5A);
        wr(8'h29, 8'h18);
        rd(8'h29, v); chk("R3 partial clear", v, 8'h42);
        wr(8'h28, 8'h20);
        rd(8'h28, v); chk("R3 single clear", v, 8'hD0);
        wr(8'h28, 8'hFF);
        rd(8'h28, v); chk("R3 clear all st0", v, 8'h00);
        wr(8'h29, 8'hFF);
        rd(8'h29, v); chk("R3 clear all st1", v, 8'h00);
    endtask

    task automatic t_collide;
        logic [7:0] v;
        pulse(4'b0000, 8'h81);
        @(negedge clk);
        addr = 8'h29; wdata = 8'hFF; wr_en = 1'b1; grp1_evt = 8'h04;
        @(negedge clk);
        wr_en = 1'b0; grp1_evt = '0;
        rd(8'h29, v); chk("R4 event beats clear", v, 8'h04);
        wr(8'h29, 8'hFF);
    endtask

    task automatic t_live;
        logic [7:0] v;
        wp_lvl = 1; cd_dat3_lvl = 0; cd_gpi_lvl = 1;
        rd(8'h28, v); chk("R5 st0 live a", v, 8'h0A);
        wp_lvl = 0; cd_dat3_lvl = 1; cd_gpi_lvl = 0;
        wr(8'h28, 8'hFF);
        rd(8'h28, v); chk("R5 st0 live b", v, 8'h04);
        cmd_busy_lvl = 1; dat_busy_lvl = 0;
        rd(8'h2A, v); chk("R5 st2 cmd busy", v, 8'h10);
        cmd_busy_lvl = 0; dat_busy_lvl = 1;
        rd(8'h2A, v); chk("R5 st2 data busy", v, 8'h20);
        dat_busy_lvl = 0; cd_dat3_lvl = 0;
    endtask

    task automatic t_freeze;
        logic [7:0] v;
        wr(8'h2A, 8'hFF);
        rd(8'h2A, v); chk("R6 st2 write", v, 8'h80);
        chk("R6 freeze pin", {7'b0, clk_freeze_en}, 8'h01);
        wr(8'h2A, 8'h00);
        chk("R6 freeze off", {7'b0, clk_freeze_en}, 8'h00);
    endtask

    task automatic t_masks;
        logic [7:0] v;
        wr(8'h24, 8'hFF);
        rd(8'h24, v); chk("R7 msk0 bits", v, 8'hF0);
        wr(8'h25, 8'hFF);
        rd(8'h25, v); chk("R7 msk1 bits", v, 8'hFE);
        wr(8'h24, 8'h00); wr(8'h25, 8'h00);
    endtask

    task automatic t_irq_timing;
        wr(8'h0D, 8'h80);
        wr(8'h25, 8'h04);
        @(negedge clk);
        grp1_evt = 8'h04;
        @(posedge clk); #1;
        grp1_evt = '0;
        chk("R9 irq not yet", {7'b0, irq}, 8'h00);
        @(posedge clk); #1;
        chk("R9 irq raised", {7'b0, irq}, 8'h01);
        @(negedge clk);
        addr = 8'h29; wdata = 8'h04; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
        chk("R9 irq still high", {7'b0, irq}, 8'h01);
        @(posedge clk); #1;
        chk("R9 irq dropped", {7'b0, irq}, 8'h00);
        wr(8'h25, 8'h00);
    endtask

    task automatic t_gate;
        wr(8'h24, 8'h80);
        wr(8'h0D, 8'h00);
        pulse(4'b1000, 8'h00);
        @(negedge clk);
        chk("R8 gated off", {7'b0, irq}, 8'h00);
        wr(8'h0D, 8'h80);
        @(negedge clk);
        chk("R8 gate on", {7'b0, irq}, 8'h01);
        wr(8'h28, 8'hFF);
        wr(8'h24, 8'h00);
        @(negedge clk);
        chk("R9 quiet after clear", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_sdio;
        logic [7:0] v;
        wr(8'h25, 8'hFF);
        pulse(4'b0000, 8'h01);
        rd(8'h29, v); chk("R10 card int latched", v, 8'h01);
        @(negedge clk); @(negedge clk);
        chk("R10 no irq", {7'b0, irq}, 8'h00);
        wr(8'h29, 8'hFF);
        wr(8'h25, 8'h00);
    endtask

    task automatic t_unmapped;
        logic [7:0] v;
        wr(8'h2B, 8'hFF);
        rd(8'h2B, v); chk("R11 st3 zero", v, 8'h00);
        wr(8'h40, 8'hFF);
        rd(8'h40, v); chk("R11 hole zero", v, 8'h00);
        rd(8'h24, v); chk("R11 hole write no alias", v, 8'h00);
        @(negedge clk);
        addr = 8'h0D;
        #1 chk("R11 idle bus", rdata, 8'h00);
    endtask

    initial begin
        #(4 * 200000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst = 1'b1; addr = '0; wr_en = 0; rd_en = 0; wdata = '0;
        grp0_evt = '0; grp1_evt = '0;
        wp_lvl = 0; cd_dat3_lvl = 0; cd_gpi_lvl = 0; cmd_busy_lvl = 0; dat_busy_lvl = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_set_clear();
        t_collide();
        t_live();
        t_freeze();
        t_masks();
        t_irq_timing();
        t_gate();
        t_sdio();
        t_unmapped();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule